// File: doc/BRIEF.md
# Pipelined Lane-Partitioned Multi-Operand Adder

This block adds a parameterised number of equal-width operands into a single result word. Through a set of run-time boundary enables, the word can be split into independent lanes. Each lane then holds the sum of its own slices of all operands, wrapped to the lane width. No carry from a lane reaches the lane above it. Typical uses are the partial-product accumulation inside a lane-configurable multiplier and packed-data reduction.

The operands first pass through a tree of 3:2 carry-save compressors. Each compressor drops its carry wherever an enabled boundary falls. When the tree is down to two words, a ripple adder that blocks carries at the same boundaries produces the result. A bit-vector parameter chooses which tree levels end in a pipeline register. The final adder counts as the level after the last compressor level. With no bits set, the block is purely combinational. The boundary enables are registered together with the data, so every stage uses the lane split that was applied with its own operands.

Top module: `padd_msum`

## Requirements
- R1: For every lane, `sum_o` equals the sum of that lane's slices of all operands, wrapped to the lane width. Operand k sits in `ops_i[k*16 +: 16]`. With the default positions, `part_en_i[0]` set places a lane boundary between bits 3 and 4, and `part_en_i[1]` set places one between bits 7 and 8.
- R2: No carry crosses an enabled boundary. Example: five operands of 0x000F with both enables set give 0x000B, and five of 0x00FF with only `part_en_i[1]` set give 0x00FB.
- R3: With all enables clear, `sum_o` is the full 16-bit sum of the operands modulo 2^16. Example: five operands of 0x000F give 0x004B.
- R4: The latency is the number of set bits of `REG_LEVELS` among levels 0 to NLEV, where NLEV is the number of compressor levels. The default 5-operand build has NLEV = 3 and `REG_LEVELS` = 4'b1010, which gives 2 cycles. The output holds the old result one cycle after an input change. With `REG_LEVELS` = 0, the result appears in the same cycle.
- R5: Boundary enables travel with their data. An enable change applied one cycle after an operand set does not alter that set's result.
- R6: With registered stages (latency > 0), `sum_o` reads 0 after a rising clock edge with `rst_i` high, whatever the inputs.
- R7: The operand count is a parameter. A 3-operand combinational build yields the R1 lane sums within the same cycle.
- R8: If the operands and enables stay unchanged for more than the latency in cycles, `sum_o` stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous active-high reset of the pipeline registers |
| ops_i | input | N_OPS*WIDTH | Operand array; operand k occupies bits k*WIDTH upward |
| part_en_i | input | NPART | Enable k cuts the carry chain at bit position PART_POS entry k |
| sum_o | output | WIDTH | Per-lane sum of all operands |

## Verification
On every cycle, the bound checker compares `sum_o` with a lane-by-lane reference sum. That reference is delayed by the configured latency and uses the enables from the same cycle as the operands. On every cycle the checker also tests the full-width sum whenever no boundary was enabled, the cleared output after reset and the steady output under steady inputs. The exact cycle at which a new result appears, the saturating overflow patterns that would expose a leaking carry, and an enable change following close behind an operand set are shown only by the directed bench scenarios.

// File: rtl/padd_pkg.sv
package padd_pkg;

   // operand count left after one level of 3:2 compression
   function automatic int ops_next(int n);
      return n - n / 3;
   endfunction

   // number of compressor levels needed to reach two operands
   function automatic int num_levels(int n);
      int c;
      int l;
      c = n;
      l = 0;
      while (c > 2) begin
         c = ops_next(c);
         l++;
      end
      return l;
   endfunction

   // operand count entering level l
   function automatic int ops_at(int n, int l);
      int c;
      c = n;
      for (int i = 0; i < l; i++) c = ops_next(c);
      return c;
   endfunction

   // latency: registered levels among 0..nlev (nlev is the final adder)
   function automatic int lat_count(logic [31:0] r, int nlev);
      int s;
      s = 0;
      for (int i = 0; i <= nlev; i++) s += int'(r[i]);
      return s;
   endfunction

   // which boundary enables sit at bit position b
   function automatic logic [31:0] hit_mask(logic [255:0] pos, int np, int b);
      logic [31:0] h;
      h = '0;
      for (int k = 0; k < np; k++)
         if (int'(pos[k*8 +: 8]) == b) h[k] = 1'b1;
      return h;
   endfunction

   // all boundary positions strictly inside the word
   function automatic bit pos_ok(logic [255:0] pos, int np, int w);
      bit ok;
      ok = 1'b1;
      for (int k = 0; k < np; k++)
         if (int'(pos[k*8 +: 8]) < 1 || int'(pos[k*8 +: 8]) > w - 1) ok = 1'b0;
      return ok;
   endfunction

endpackage

// File: rtl/padd_part_map.sv
module padd_part_map #(
   parameter int                   WIDTH    = 16,
   parameter int                   NPART    = 2,
   parameter logic [NPART*8-1:0]   PART_POS = {8'd8, 8'd4}
) (
   input  logic [NPART-1:0] part_en_i,
   output logic [WIDTH-1:0] blk_o      // blk_o[i]: carry into bit i is cut
);
   localparam logic [255:0] POSX = 256'(PART_POS);

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      localparam logic [31:0] HIT = padd_pkg::hit_mask(POSX, NPART, b);
      assign blk_o[b] = |(part_en_i & HIT[NPART-1:0]);
   end
endmodule

// File: rtl/padd_csa_level.sv
module padd_csa_level #(
   parameter int                   WIDTH    = 16,
   parameter int                   NPART    = 2,
   parameter logic [NPART*8-1:0]   PART_POS = {8'd8, 8'd4},
   parameter int                   NI       = 3,
   parameter int                   NO       = 2
) (
   input  logic [NI*WIDTH-1:0] ops_i,
   input  logic [NPART-1:0]    part_en_i,
   output logic [NO*WIDTH-1:0] ops_o
);
   localparam int NG = NI / 3;
   localparam int NR = NI - 3 * NG;

   if (NO != 2 * NG + NR) begin : g_bad_count
      $error("padd_csa_level: output count does not match compression");
   end

   logic [WIDTH-1:0] blk;

   padd_part_map #(.WIDTH(WIDTH), .NPART(NPART), .PART_POS(PART_POS)) u_map (
      .part_en_i (part_en_i),
      .blk_o     (blk)
   );

   for (genvar g = 0; g < NG; g++) begin : g_csa
      logic [WIDTH-1:0] x, y, z, maj;
      assign x   = ops_i[(3*g)*WIDTH   +: WIDTH];
      assign y   = ops_i[(3*g+1)*WIDTH +: WIDTH];
      assign z   = ops_i[(3*g+2)*WIDTH +: WIDTH];
      assign maj = (x & y) | (x & z) | (y & z);
      assign ops_o[(2*g)*WIDTH   +: WIDTH] = x ^ y ^ z;
      // carry moves up one bit and is dropped where a lane boundary sits
      assign ops_o[(2*g+1)*WIDTH +: WIDTH] = {maj[WIDTH-2:0], 1'b0} & ~blk;
   end

   for (genvar r = 0; r < NR; r++) begin : g_pass
      assign ops_o[(2*NG+r)*WIDTH +: WIDTH] = ops_i[(3*NG+r)*WIDTH +: WIDTH];
   end
endmodule

// File: rtl/padd_lane_adder.sv
module padd_lane_adder #(
   parameter int                   WIDTH    = 16,
   parameter int                   NPART    = 2,
   parameter logic [NPART*8-1:0]   PART_POS = {8'd8, 8'd4}
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [NPART-1:0] part_en_i,
   output logic [WIDTH-1:0] sum_o
);
   logic [WIDTH-1:0] blk;

   padd_part_map #(.WIDTH(WIDTH), .NPART(NPART), .PART_POS(PART_POS)) u_map (
      .part_en_i (part_en_i),
      .blk_o     (blk)
   );

   always_comb begin
      logic c;
      logic cin;
      c = 1'b0;
      for (int i = 0; i < WIDTH; i++) begin
         cin      = blk[i] ? 1'b0 : c;
         sum_o[i] = a_i[i] ^ b_i[i] ^ cin;
         c        = (a_i[i] & b_i[i]) | (a_i[i] & cin) | (b_i[i] & cin);
      end
   end
endmodule

// File: rtl/padd_stage_reg.sv
module padd_stage_reg #(
   parameter int W   = 8,
   parameter bit REG = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (REG) begin : g_flop
      always_ff @(posedge clk_i) begin
         if (rst_i) q_o <= '0;
         else       q_o <= d_i;
      end
   end else begin : g_wire
      logic unused_clk_rst;
      assign unused_clk_rst = clk_i ^ rst_i;
      assign q_o = d_i;
   end
endmodule

// File: rtl/padd_msum.sv
module padd_msum #(
   parameter int                   WIDTH      = 16,
   parameter int                   N_OPS      = 5,
   parameter int                   NPART      = 2,
   parameter logic [NPART*8-1:0]   PART_POS   = {8'd8, 8'd4},
   parameter logic [31:0]          REG_LEVELS = 32'b1010
) (
   input  logic                    clk_i,
   input  logic                    rst_i,
   input  logic [N_OPS*WIDTH-1:0]  ops_i,
   input  logic [NPART-1:0]        part_en_i,
   output logic [WIDTH-1:0]        sum_o
);
   localparam int NLEV = padd_pkg::num_levels(N_OPS);
   localparam int LAT  = padd_pkg::lat_count(REG_LEVELS, NLEV);

   // elaboration-time parameter checks
   if (WIDTH < 2)  begin : g_chk_w  $error("padd_msum: WIDTH must be at least 2"); end
   if (N_OPS < 2)  begin : g_chk_n  $error("padd_msum: N_OPS must be at least 2"); end
   if (NPART < 1 || NPART > 32) begin : g_chk_p $error("padd_msum: NPART out of range"); end
   if (NLEV > 31)  begin : g_chk_l  $error("padd_msum: too many tree levels for REG_LEVELS"); end
   if (!padd_pkg::pos_ok(256'(PART_POS), NPART, WIDTH)) begin : g_chk_pos
      $error("padd_msum: boundary position outside the word");
   end

   // compressor levels, each optionally registered with its enables
   for (genvar l = 0; l < NLEV; l++) begin : g_lvl
      localparam int NI = padd_pkg::ops_at(N_OPS, l);
      localparam int NO = padd_pkg::ops_at(N_OPS, l + 1);

      logic [NI*WIDTH-1:0] d_in;
      logic [NPART-1:0]    e_in;
      logic [NO*WIDTH-1:0] d_cmb;
      logic [NO*WIDTH-1:0] d_out;
      logic [NPART-1:0]    e_out;

      if (l == 0) begin : g_src
         assign d_in = ops_i;
         assign e_in = part_en_i;
      end else begin : g_chain
         assign d_in = g_lvl[l-1].d_out;
         assign e_in = g_lvl[l-1].e_out;
      end

      padd_csa_level #(
         .WIDTH(WIDTH), .NPART(NPART), .PART_POS(PART_POS), .NI(NI), .NO(NO)
      ) u_csa (
         .ops_i     (d_in),
         .part_en_i (e_in),
         .ops_o     (d_cmb)
      );

      padd_stage_reg #(.W(NO*WIDTH + NPART), .REG(REG_LEVELS[l])) u_reg (
         .clk_i (clk_i),
         .rst_i (rst_i),
         .d_i   ({e_in, d_cmb}),
         .q_o   ({e_out, d_out})
      );
   end

   // final carry-blocking adder on the last two words
   logic [2*WIDTH-1:0] fin_d;
   logic [NPART-1:0]   fin_e;
   logic [WIDTH-1:0]   fin_sum;

   if (NLEV == 0) begin : g_direct
      assign fin_d = ops_i;
      assign fin_e = part_en_i;
   end else begin : g_tail
      assign fin_d = g_lvl[NLEV-1].d_out;
      assign fin_e = g_lvl[NLEV-1].e_out;
   end

   padd_lane_adder #(.WIDTH(WIDTH), .NPART(NPART), .PART_POS(PART_POS)) u_add (
      .a_i       (fin_d[WIDTH-1:0]),
      .b_i       (fin_d[2*WIDTH-1:WIDTH]),
      .part_en_i (fin_e),
      .sum_o     (fin_sum)
   );

   padd_stage_reg #(.W(WIDTH), .REG(REG_LEVELS[NLEV])) u_out (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .d_i   (fin_sum),
      .q_o   (sum_o)
   );
endmodule

// File: rtl/padd_msum_chk.sv
module padd_msum_chk #(
   parameter int                   WIDTH    = 16,
   parameter int                   N_OPS    = 5,
   parameter int                   NPART    = 2,
   parameter logic [NPART*8-1:0]   PART_POS = {8'd8, 8'd4},
   parameter int                   LAT      = 0
) (
   input  logic                    clk_i,
   input  logic                    rst_i,
   input  logic [N_OPS*WIDTH-1:0]  ops_i,
   input  logic [NPART-1:0]        part_en_i,
   input  logic [WIDTH-1:0]        sum_o
);
   localparam int PW = 2 * WIDTH + 1;

   // reference: sum each lane separately with a loop over bit positions
   function automatic logic [WIDTH-1:0] lane_ref(logic [N_OPS*WIDTH-1:0] v,
                                                 logic [NPART-1:0] en);
      logic [WIDTH-1:0] r;
      logic [WIDTH-1:0] msk;
      logic [WIDTH-1:0] acc;
      int lo;
      bit cut;
      r  = '0;
      lo = 0;
      for (int i = 1; i <= WIDTH; i++) begin
         cut = (i == WIDTH);
         for (int k = 0; k < NPART; k++)
            if (en[k] && int'(PART_POS[k*8 +: 8]) == i) cut = 1'b1;
         if (cut) begin
            msk = '0;
            for (int j = lo; j < i; j++) msk[j] = 1'b1;
            acc = '0;
            for (int o = 0; o < N_OPS; o++) acc += v[o*WIDTH +: WIDTH] & msk;
            r  |= acc & msk;
            lo  = i;
         end
      end
      return r;
   endfunction

   function automatic logic [WIDTH-1:0] full_ref(logic [N_OPS*WIDTH-1:0] v);
      logic [WIDTH-1:0] acc;
      acc = '0;
      for (int o = 0; o < N_OPS; o++) acc += v[o*WIDTH +: WIDTH];
      return acc;
   endfunction

   logic [PW-1:0] now_v;
   logic [PW-1:0] old_v;
   assign now_v = {part_en_i == '0, full_ref(ops_i), lane_ref(ops_i, part_en_i)};

   if (LAT == 0) begin : g_nodly
      assign old_v = now_v;
   end else begin : g_dly
      logic [PW-1:0] sr [LAT];
      always_ff @(posedge clk_i) begin
         sr[0] <= now_v;
         for (int i = 1; i < LAT; i++) sr[i] <= sr[i-1];
      end
      assign old_v = sr[LAT-1];
   end

   // cycles since reset, saturating at the latency
   int fill;
   always_ff @(posedge clk_i) begin
      if (rst_i)           fill <= 0;
      else if (fill < LAT) fill <= fill + 1;
   end
   logic ready;
   assign ready = (fill == LAT);

   // run of unchanged input cycles
   logic [N_OPS*WIDTH-1:0] prev_ops;
   logic [NPART-1:0]       prev_en;
   int                     run;
   logic                   same;
   assign same = (ops_i == prev_ops) && (part_en_i == prev_en);
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         prev_ops <= '0;
         prev_en  <= '0;
         run      <= 0;
      end else begin
         prev_ops <= ops_i;
         prev_en  <= part_en_i;
         if (!same)        run <= 0;
         else if (run <= LAT) run <= run + 1;
      end
   end

   // R1 and R2: per-lane sums, no carry across an enabled boundary
   assert_lane_sum_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      ready |-> (sum_o == old_v[WIDTH-1:0]));

   // R3: whole-word sum when no boundary was enabled
   assert_full_sum_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (ready && old_v[PW-1]) |-> (sum_o == old_v[2*WIDTH-1:WIDTH]));

   // R8: steady inputs give a steady output
   assert_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      (ready && same && run > LAT) |-> (sum_o == $past(sum_o)));

   if (LAT > 0) begin : g_rst_chk
      // R6: registered pipeline clears on synchronous reset
      assert_reset_clear_R6: assert property (@(posedge clk_i) disable iff (rst_i)
         $past(rst_i) |-> (sum_o == '0));
   end
endmodule

bind padd_msum padd_msum_chk #(
   .WIDTH(WIDTH), .N_OPS(N_OPS), .NPART(NPART), .PART_POS(PART_POS), .LAT(LAT)
) u_chk (
   .clk_i     (clk_i),
   .rst_i     (rst_i),
   .ops_i     (ops_i),
   .part_en_i (part_en_i),
   .sum_o     (sum_o)
);

// File: tb/padd_msum_test.sv
`timescale 1ns/1ps
module padd_msum_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [79:0] ops = '0;
   logic [1:0]  pen = '0;
   logic [15:0] sum;
   logic [47:0] ops3 = '0;
   logic [15:0] sum3;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   // default build: 5 operands, latency 2
   padd_msum uut (
      .clk_i(clk), .rst_i(rst), .ops_i(ops), .part_en_i(pen), .sum_o(sum)
   );

   // 3-operand combinational build
   padd_msum #(.N_OPS(3), .REG_LEVELS(32'd0)) uut_comb (
      .clk_i(clk), .rst_i(rst), .ops_i(ops3), .part_en_i(pen), .sum_o(sum3)
   );

   // bench model: boundary at 4 if pen[0], at 8 if pen[1]
   function automatic logic [15:0] model(logic [79:0] v, int n, logic [1:0] en);
      logic [15:0] r;
      int lo;
      r  = '0;
      lo = 0;
      for (int hi = 1; hi <= 16; hi++) begin
         if (hi == 16 || (hi == 4 && en[0]) || (hi == 8 && en[1])) begin
            int s;
            int m;
            s = 0;
            m = (1 << (hi - lo)) - 1;
            for (int o = 0; o < n; o++) s += (int'(v[o*16 +: 16]) >> lo) & m;
            r |= 16'((s & m) << lo);
            lo = hi;
         end
      end
      return r;
   endfunction

   function automatic logic [79:0] pk(logic [15:0] a, logic [15:0] b, logic [15:0] c,
                                      logic [15:0] d, logic [15:0] e);
      return {e, d, c, b, a};
   endfunction

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
      end
   endtask

   task automatic drive(logic [79:0] v, logic [1:0] en);
      @(negedge clk);
      ops  = v;
      ops3 = v[47:0];
      pen  = en;
   endtask

   // drive, check combinational build now and pipelined build after 2 edges
   task automatic apply_check(string req, logic [79:0] v, logic [1:0] en);
      drive(v, en);
      #1;
      check({req, " comb R7"}, sum3, model(v, 3, en));
      repeat (2) @(posedge clk);
      #1;
      check(req, sum, model(v, 5, en));
   endtask

   task automatic t_reset;
      rst = 1'b1;
      ops = pk(16'h1234, 16'h0F0F, 16'hFFFF, 16'h8001, 16'h00AA);
      ops3 = ops[47:0];
      pen = 2'b11;
      repeat (3) @(posedge clk);
      #1;
      check("R6 reset clears output", sum, 16'h0000);
      check("R4 comb build live during reset", sum3, model(ops, 3, 2'b11));
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic t_lanes;
      apply_check("R1 lanes 4/4/8", pk(16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 16'h0FED), 2'b11);
      apply_check("R1 lanes 4/12",  pk(16'hA5A5, 16'h5A5A, 16'h3C3C, 16'hC3C3, 16'h7777), 2'b01);
      apply_check("R1 lanes 8/8",   pk(16'hFFFF, 16'h8080, 16'h0101, 16'h7F7F, 16'h4242), 2'b10);
      apply_check("R3 full width",  pk(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF), 2'b00);
   endtask

   task automatic t_isolation;
      drive(pk(16'h000F, 16'h000F, 16'h000F, 16'h000F, 16'h000F), 2'b11);
      repeat (2) @(posedge clk); #1;
      check("R2 nibble lane overflow", sum, 16'h000B);
      drive(pk(16'h000F, 16'h000F, 16'h000F, 16'h000F, 16'h000F), 2'b00);
      repeat (2) @(posedge clk); #1;
      check("R3 carries spread when uncut", sum, 16'h004B);
      drive(pk(16'h00FF, 16'h00FF, 16'h00FF, 16'h00FF, 16'h00FF), 2'b10);
      repeat (2) @(posedge clk); #1;
      check("R2 byte lane overflow", sum, 16'h00FB);
      drive(pk(16'h00FF, 16'h00FF, 16'h00FF, 16'h00FF, 16'h00FF), 2'b01);
      repeat (2) @(posedge clk); #1;
      check("R2 cut at bit 4 only", sum, 16'h04BB);
   endtask

   task automatic t_latency;
      logic [79:0] a;
      logic [79:0] b;
      a = pk(16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555);
      b = pk(16'hF00D, 16'hBEEF, 16'hCAFE, 16'h0BAD, 16'h1357);
      drive(a, 2'b00);
      repeat (3) @(posedge clk); #1;
      drive(b, 2'b00);
      @(posedge clk); #1;
      check("R4 old result after one cycle", sum, model(a, 5, 2'b00));
      @(posedge clk); #1;
      check("R4 new result after two cycles", sum, model(b, 5, 2'b00));
   endtask

   task automatic t_stream;
      logic [79:0] a;
      logic [79:0] b;
      a = pk(16'h0FFF, 16'h0FFF, 16'h00F1, 16'h1F1F, 16'h0808);
      b = pk(16'h0FFF, 16'h0FFF, 16'h00F1, 16'h1F1F, 16'h0808);
      drive(a, 2'b11);
      drive(b, 2'b00);
      @(posedge clk); #1;
      check("R5 first set keeps its cuts", sum, model(a, 5, 2'b11));
      @(posedge clk); #1;
      check("R5 second set keeps its cuts", sum, model(b, 5, 2'b00));
   endtask

   task automatic t_hold;
      logic [15:0] first;
      drive(pk(16'h2468, 16'h1357, 16'hFEDC, 16'h0001, 16'h8000), 2'b10);
      repeat (3) @(posedge clk); #1;
      first = sum;
      check("R8 settled value", first, model(pk(16'h2468, 16'h1357, 16'hFEDC, 16'h0001, 16'h8000), 5, 2'b10));
      repeat (2) @(posedge clk); #1;
      check("R8 value held", sum, first);
   endtask

   task automatic t_comb;
      drive(pk(16'h000F, 16'h000F, 16'h000F, 16'h0, 16'h0), 2'b11);
      #1;
      check("R7 comb nibble wrap", sum3, 16'h000D);
      drive(pk(16'hFFFF, 16'h0001, 16'h8000, 16'h0, 16'h0), 2'b00);
      #1;
      check("R7 comb full width", sum3, 16'h8000);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_lanes();
      t_isolation();
      t_latency();
      t_stream();
      t_hold();
      t_comb();
      repeat (2) @(posedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule